// File: doc/BRIEF.md
# Fixed-Period Pulse-Width Generator with Byte Register Port

This block produces one pulse-width modulated output with a fixed period of 1 ms. The period is split into 256 equal sub-steps. A host programs an 8-bit duty code through a simple synchronous byte-wide register port, and sets an enable bit in a separate settings register to let the pin be driven. While enabled, the pin is high for (code + 1) of the 256 sub-steps in every period, so the smallest pulse is one sub-step and code 255 gives a constant high level. A true 0 % duty cannot be produced. A host that needs the pin low clears the enable bit, which releases the pad driver. An external pull-down then holds the line low.

The sub-step timebase is derived from a parameterized input clock. It runs from reset onward and nothing the host writes restarts it. Duty and enable writes act at once, inside the period in which they land. That period may therefore show one shortened or lengthened pulse. The pad is exposed as a separate data signal and driver-enable signal, so the tri-state buffer and the pull-down sit outside the block.

Top module: `pwm_fp_top`

## Requirements
- R1: After reset, both registers read 0x00 and pad_oe is 0, so the modelled pin is low.
- R2: With duty code C at byte address 0xD8, pad_o is high for exactly (C+1)*CLKS_PER_STEP clock cycles out of every 256*CLKS_PER_STEP. Code 0 gives one sub-step and code 255 gives a constant high level.
- R3: The period is 256*CLKS_PER_STEP clock cycles with CLKS_PER_STEP = CLK_HZ/(PERIOD_HZ*256). Rising edges of pad_o stay on that grid across enable toggles and duty writes.
- R4: A write to address 0xD8 stores all 8 bits of the duty code, and a read of 0xD8 returns them.
- R5: A write to address 0xD2 stores all 8 bits of the settings register, and a read returns them unchanged. Bit 7 of that register is the output enable.
- R6: While bit 7 of 0xD2 is 0, pad_oe is 0 and the pin is released, but pad_o keeps following the duty pattern.
- R7: A duty write takes effect from the next clock cycle, so it alters the pulse of the period in which it lands.
- R8: Writes to any address other than 0xD2 and 0xD8 change no register and no output. Reads of those addresses return 0x00.
- R9: pad_oe equals the written bit 7 from the clock cycle after a write to 0xD2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pad_o | output | 1 | Pad data level |
| pad_oe | output | 1 | Pad driver enable; 0 releases the pin |

## Verification
The properties assume that reg_wr, reg_addr and reg_wdata are stable around each rising edge. They also assume that the clock parameters divide evenly, so a whole number of clock cycles forms each sub-step. The bench drives every register access on the falling edge, and it chooses CLK_HZ as an exact multiple of 256 times PERIOD_HZ. Duty writes in the alignment test are placed in sub-step 0 of a period, where any code keeps pad_o high. This means an extra rising edge can only come from a timebase fault, never from the allowed glitch.

// File: rtl/pwm_fp_pkg.sv
package pwm_fp_pkg;

  localparam int unsigned REG_W       = 8;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned CTRL_EN_BIT = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'hD2;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 8'hD8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DUTY = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
    reg_sel_e sel;
    if (addr == ADDR_CTRL)      sel = SEL_CTRL;
    else if (addr == ADDR_DUTY) sel = SEL_DUTY;
    else                        sel = SEL_NONE;
    return sel;
  endfunction

endpackage

// File: rtl/pwm_fp_timebase.sv
module pwm_fp_timebase #(
  parameter int unsigned CLKS_PER_STEP = 100,
  parameter int unsigned STEP_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              step_tick,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d
);

  localparam int unsigned PRE_W = (CLKS_PER_STEP > 1) ? $clog2(CLKS_PER_STEP) : 1;

  generate
    if (CLKS_PER_STEP <= 1) begin : g_no_pre
      assign step_tick = 1'b1;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_STEP - 1);
      logic [PRE_W-1:0] pre_q, pre_d;

      always_comb begin
        if (pre_q == PRE_LAST) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign step_tick = (pre_q == PRE_LAST);
    end
  endgenerate

  always_comb begin
    step_d = step_q;
    if (step_tick) step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/pwm_fp_regs.sv
module pwm_fp_regs
  import pwm_fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  ctrl_d,
  output logic [REG_W-1:0]  duty_q,
  output logic [REG_W-1:0]  duty_d
);

  reg_sel_e sel;
  logic     ctrl_ld, duty_ld;

  assign sel     = decode_addr(reg_addr);
  assign ctrl_ld = reg_wr && (sel == SEL_CTRL);
  assign duty_ld = reg_wr && (sel == SEL_DUTY);

  always_comb begin
    ctrl_d = ctrl_q;
    duty_d = duty_q;
    if (ctrl_ld) ctrl_d = reg_wdata;
    if (duty_ld) duty_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (duty_ld) duty_q <= duty_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_DUTY: reg_rdata = duty_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_fp_outstage.sv
module pwm_fp_outstage #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_d,
  input  logic [STEP_W-1:0] duty_d,
  input  logic              en_d,
  output logic              pad_o,
  output logic              pad_oe
);

  logic level_d;

  // Compare the values the step and duty registers are about to take,
  // so pad_o lines up with them and a write acts on the next cycle.
  assign level_d = (step_d <= duty_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_o  <= 1'b1;
      pad_oe <= 1'b0;
    end else begin
      pad_o  <= level_d;
      pad_oe <= en_d;
    end
  end

endmodule

// File: rtl/pwm_fp_top.sv
module pwm_fp_top
  import pwm_fp_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 25_600_000,
  parameter int unsigned PERIOD_HZ = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              pad_o,
  output logic              pad_oe
);

  localparam int unsigned STEPS         = 1 << REG_W;
  localparam int unsigned CLKS_PER_STEP = CLK_HZ / (PERIOD_HZ * STEPS);

  logic             step_tick;
  logic [REG_W-1:0] step_q, step_d;
  logic [REG_W-1:0] ctrl_q, ctrl_d, duty_q, duty_d;

  pwm_fp_timebase #(
    .CLKS_PER_STEP(CLKS_PER_STEP),
    .STEP_W       (REG_W)
  ) tb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_tick(step_tick),
    .step_q   (step_q),
    .step_d   (step_d)
  );

  pwm_fp_regs regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ctrl_q   (ctrl_q),
    .ctrl_d   (ctrl_d),
    .duty_q   (duty_q),
    .duty_d   (duty_d)
  );

  pwm_fp_outstage #(
    .STEP_W(REG_W)
  ) out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step_d(step_d),
    .duty_d(duty_d),
    .en_d  (ctrl_d[CTRL_EN_BIT]),
    .pad_o (pad_o),
    .pad_oe(pad_oe)
  );

endmodule

// File: rtl/pwm_fp_chk.sv
module pwm_fp_chk
  import pwm_fp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              pad_o,
  input logic              pad_oe,
  input logic              step_tick,
  input logic [REG_W-1:0]  step_q,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  duty_q
);

  logic mapped;
  assign mapped = (reg_addr == ADDR_CTRL) || (reg_addr == ADDR_DUTY);

  p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(step_q));

  p_step_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick |=> (step_q == REG_W'($past(step_q) + 1'b1)));

  p_full_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == 8'hFF) |-> pad_o);

  p_first_step_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == '0) |-> pad_o);

  p_duty_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DUTY) |=> (duty_q == $past(reg_wdata)));

  p_oe_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CTRL) |=> (pad_oe == $past(reg_wdata[CTRL_EN_BIT])));

  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> ($stable(duty_q) && $stable(ctrl_q)));

  p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));

endmodule

bind pwm_fp_top pwm_fp_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .pad_o    (pad_o),
  .pad_oe   (pad_oe),
  .step_tick(step_tick),
  .step_q   (step_q),
  .ctrl_q   (ctrl_q),
  .duty_q   (duty_q)
);

// File: tb/pwm_fp_top_tb_top.sv
module pwm_fp_top_tb_top;

  localparam int unsigned CLK_HZ    = 1_024_000;
  localparam int unsigned PERIOD_HZ = 1000;
  localparam int          CPS       = CLK_HZ / (PERIOD_HZ * 256);
  localparam int          PER       = 256 * CPS;
  localparam logic [7:0]  A_CTRL    = 8'hD2;
  localparam logic [7:0]  A_DUTY    = 8'hD8;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pad_o;
  logic       pad_oe;
  logic       pin;

  int     n_checks = 0;
  int     n_errors = 0;
  bit     done     = 0;
  longint cyc      = 0;

  pwm_fp_top #(.CLK_HZ(CLK_HZ), .PERIOD_HZ(PERIOD_HZ)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe)
  );

  // Pad model: released driver is pulled low externally.
  assign pin = pad_oe ? pad_o : 1'b0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_edge(input logic lvl, output longint t);
    logic prev;
    prev = pad_o;
    forever begin
      @(negedge clk);
      if (pad_o == lvl && prev != lvl) break;
      prev = pad_o;
    end
    t = cyc;
  endtask

  task automatic count_high(output int n_pin, output int n_pad);
    n_pin = 0;
    n_pad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pin)   n_pin++;
      if (pad_o) n_pad++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pin", pin, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_DUTY, d); chk("R1 duty", d, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(A_DUTY, 8'h5A);
    rd(A_DUTY, d); chk("R4 duty readback", d, 8'h5A);
    wr(A_CTRL, 8'h3F);
    rd(A_CTRL, d); chk("R5 ctrl readback", d, 8'h3F);
    chk("R9 oe off", pad_oe, 0);
    wr(A_CTRL, 8'hC1);
    chk("R9 oe on", pad_oe, 1);
    rd(A_CTRL, d); chk("R5 other bits kept", d, 8'hC1);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'hD3, 8'h00);
    wr(8'hD9, 8'hFF);
    wr(8'h00, 8'h00);
    rd(A_CTRL, d); chk("R8 ctrl untouched", d, 8'hC1);
    rd(A_DUTY, d); chk("R8 duty untouched", d, 8'h5A);
    chk("R8 oe untouched", pad_oe, 1);
    rd(8'hD3, d); chk("R8 read zero", d, 0);
  endtask

  task automatic t_duty(input int code);
    int np, nd;
    wr(A_CTRL, 8'h80);
    wr(A_DUTY, code[7:0]);
    count_high(np, nd);
    chk($sformatf("R2 high cycles code %0d", code), np, (code + 1) * CPS);
  endtask

  task automatic t_disabled;
    int np, nd;
    wr(A_DUTY, 8'd63);
    wr(A_CTRL, 8'h00);
    chk("R6 oe released", pad_oe, 0);
    count_high(np, nd);
    chk("R6 pin low", np, 0);
    chk("R6 pad_o keeps running", nd, 64 * CPS);
  endtask

  task automatic t_align;
    longint t0, tf, tr;
    int codes[3] = '{30, 100, 200};
    wr(A_DUTY, 8'd200);
    wr(A_CTRL, 8'h80);
    wait_edge(1'b1, t0);
    for (int i = 0; i < 3; i++) begin
      wr(A_DUTY, codes[i][7:0]);
      wr(A_CTRL, (i % 2 == 0) ? 8'h00 : 8'h80);
      chk("R9 toggle", pad_oe, (i % 2 == 0) ? 0 : 1);
      wait_edge(1'b0, tf);
      chk("R7 fall in same period", tf - t0, (codes[i] + 1) * CPS);
      wait_edge(1'b1, tr);
      chk("R3 period grid", tr - t0, PER);
      t0 = tr;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_duty(0);
    t_duty(127);
    t_duty(255);
    t_disabled();
    t_align();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule